// File: doc/BRIEF.md
# DDR2 Rank Refresh Scheduler with Temperature Derating

This block decides when one DDR2 rank owes an auto-refresh and tells the command arbiter. A free-running interval timer adds one owed refresh each time it expires. The period is the normal average refresh interval, or half of it when the high-temperature flag is set at the moment an interval begins. Owed refreshes build up in a bounded counter, so the arbiter may postpone a few of them. When the counter is full, an urgent flag is raised. The arbiter answers a request with a one-cycle grant when it issues the REFRESH command; the block then withdraws the command permits for the refresh cycle time.

The block also runs the rank's self-refresh sequence. While a self-refresh request is held, the block drops clock-enable once no refresh cycle is running and clock-enable has kept its level for the minimum time. During self-refresh the interval timer is frozen, owed refreshes are forgotten and no command is permitted. When the request is released, clock-enable rises and two separate recovery windows start: one for non-READ commands and a longer one for READs. The interval timer restarts at that point. Every timing value is a parameter counted in clock cycles. The defaults suit a 2.5 ns clock.

Top module: `ddr_refresh_sched`

## Requirements
- R1: After reset `ref_pending_o` is 0, `ref_req_o` and `ref_urgent_o` are 0, and `cke_o`, `cmd_allow_o` and `rd_allow_o` are 1. While the temperature flag is low, one refresh becomes owed every `T_REFI` cycles, counted from reset release. The owed count never rises by more than one per cycle.
- R2: An interval that starts with `temp_hi_i` high lasts `T_REFI/2` cycles. A change of the flag during an interval takes effect only at the next interval start.
- R3: `ref_req_o` is high exactly when the block is running normally, at least one refresh is owed and no refresh cycle is in progress.
- R4: A grant in a cycle where `ref_req_o` is high lowers the owed count by one. If the timer expires in the same cycle, the count is left unchanged. A grant while `ref_req_o` is low has no effect.
- R5: The owed count saturates at `MAX_PEND`. `ref_urgent_o` is high exactly when the count equals `MAX_PEND`.
- R6: After an accepted grant, `cmd_allow_o` and `rd_allow_o` are low for `T_RFC` cycles and high again in the cycle after that.
- R7: Self-refresh entry needs four things in the same cycle: `sref_req_i` high, normal operation, no refresh cycle in progress and no accepted grant. `cke_o` then falls in the next cycle and the owed count becomes 0. While `cke_o` is low, no permit and no request is given, and the interval timer does not advance.
- R8: `cke_o` keeps each level for at least `T_CKE` cycles. A release of the request that comes earlier is acted on once the minimum has passed.
- R9: After `cke_o` rises, `cmd_allow_o` returns `T_XSNR` cycles later and `rd_allow_o` returns `T_XSRD` cycles later. The interval timer restarts in the cycle `cke_o` rises, and its length is chosen by the temperature flag at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_hi_i | input | 1 | Case temperature above the normal range; halves the next interval |
| sref_req_i | input | 1 | Hold high to keep the rank in self-refresh |
| ref_grant_i | input | 1 | Arbiter issued a REFRESH this cycle |
| ref_req_o | output | 1 | A refresh is owed and may be issued now |
| ref_urgent_o | output | 1 | Postponement limit reached |
| ref_pending_o | output | $clog2(MAX_PEND+1) | Number of owed refreshes |
| cmd_allow_o | output | 1 | Non-READ commands may be issued |
| rd_allow_o | output | 1 | READ commands may be issued |
| cke_o | output | 1 | Clock-enable level for the rank |

## Verification
The cycle-level checks cover several invariants. The owed count stays bounded and moves by at most one per cycle. An accepted grant always clears both permits in the following cycle. No permit and no request appears while clock-enable is low, and clock-enable never changes level before its minimum run. READ permission never comes without non-READ permission. The exact lengths of the normal and derated intervals, the point at which a temperature change takes effect, and the lengths of the two recovery windows after self-refresh exit can only be observed over whole scenarios. The bench's timestamp model checks these on every cycle while it drives grants, temperature changes and short and long self-refresh requests.

// File: rtl/rsch_pkg.sv
package rsch_pkg;
    // Power sequencer states
    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_SELF = 2'd1,
        PWR_WAKE = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/rsch_interval.sv
// Interval timer: one tick per average refresh interval, derated length
// chosen when an interval starts.
module rsch_interval #(
    parameter int unsigned T_REFI = 3120
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic restart_i,
    input  logic temp_hi_i,
    output logic tick_o
);
    localparam int unsigned T_HOT = T_REFI / 2;
    localparam int unsigned CW    = $clog2(T_REFI);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ival_regs_t;

    ival_regs_t cur_q, nxt_d;
    logic [CW-1:0] reload_val;

    always_comb begin
        nxt_d      = cur_q;
        tick_o     = 1'b0;
        reload_val = temp_hi_i ? CW'(T_HOT - 1) : CW'(T_REFI - 1);
        if (restart_i) begin
            nxt_d.cnt = reload_val;
        end else if (run_i) begin
            if (cur_q.cnt == '0) begin
                tick_o    = 1'b1;
                nxt_d.cnt = reload_val;
            end else begin
                nxt_d.cnt = cur_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.cnt <= CW'(T_REFI - 1);
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/rsch_pending.sv
// Saturating count of owed refreshes.
module rsch_pending #(
    parameter int unsigned MAX_PEND = 8,
    parameter int unsigned PW       = $clog2(MAX_PEND + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          take_i,
    input  logic          clear_i,
    output logic [PW-1:0] count_o,
    output logic          full_o
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } pend_regs_t;

    pend_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clear_i) begin
            nxt_d.cnt = '0;
        end else if (tick_i && !take_i) begin
            if (cur_q.cnt != PW'(MAX_PEND)) begin
                nxt_d.cnt = cur_q.cnt + PW'(1);
            end
        end else if (take_i && !tick_i) begin
            if (cur_q.cnt != '0) begin
                nxt_d.cnt = cur_q.cnt - PW'(1);
            end
        end
    end

    assign count_o = cur_q.cnt;
    assign full_o  = (cur_q.cnt == PW'(MAX_PEND));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.cnt <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/rsch_power.sv
// Self-refresh sequencer: clock-enable control, minimum level time and
// the two wake-up recovery windows.
module rsch_power
    import rsch_pkg::*;
#(
    parameter int unsigned T_CKE  = 3,
    parameter int unsigned T_XSNR = 55,
    parameter int unsigned T_XSRD = 200
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sref_req_i,
    input  logic quiet_i,
    output logic cke_o,
    output logic run_o,
    output logic self_o,
    output logic enter_o,
    output logic exit_o,
    output logic nrd_ok_o,
    output logic rd_ok_o
);
    localparam int unsigned HW = (T_CKE > 1) ? $clog2(T_CKE) : 1;
    localparam int unsigned NW = $clog2(T_XSNR + 1);
    localparam int unsigned RW = $clog2(T_XSRD + 1);

    typedef struct packed {
        pwr_state_e    state;
        logic          cke;
        logic [HW-1:0] hold;
        logic [NW-1:0] nrd;
        logic [RW-1:0] rd;
    } pwr_regs_t;

    pwr_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d   = cur_q;
        enter_o = 1'b0;
        exit_o  = 1'b0;
        if (cur_q.hold != '0) nxt_d.hold = cur_q.hold - HW'(1);
        if (cur_q.nrd  != '0) nxt_d.nrd  = cur_q.nrd  - NW'(1);
        if (cur_q.rd   != '0) nxt_d.rd   = cur_q.rd   - RW'(1);
        unique case (cur_q.state)
            PWR_RUN: begin
                if (sref_req_i && quiet_i && cur_q.hold == '0) begin
                    nxt_d.state = PWR_SELF;
                    nxt_d.cke   = 1'b0;
                    nxt_d.hold  = HW'(T_CKE - 1);
                    enter_o     = 1'b1;
                end
            end
            PWR_SELF: begin
                if (!sref_req_i && cur_q.hold == '0) begin
                    nxt_d.state = PWR_WAKE;
                    nxt_d.cke   = 1'b1;
                    nxt_d.hold  = HW'(T_CKE - 1);
                    nxt_d.nrd   = NW'(T_XSNR);
                    nxt_d.rd    = RW'(T_XSRD);
                    exit_o      = 1'b1;
                end
            end
            PWR_WAKE: begin
                if (cur_q.rd == '0) nxt_d.state = PWR_RUN;
            end
            default: nxt_d.state = PWR_RUN;
        endcase
    end

    assign cke_o    = cur_q.cke;
    assign run_o    = (cur_q.state == PWR_RUN);
    assign self_o   = (cur_q.state == PWR_SELF);
    assign nrd_ok_o = (cur_q.state == PWR_RUN) ||
                      (cur_q.state == PWR_WAKE && cur_q.nrd == '0);
    assign rd_ok_o  = (cur_q.state == PWR_RUN) ||
                      (cur_q.state == PWR_WAKE && cur_q.rd == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.state <= PWR_RUN;
            cur_q.cke   <= 1'b1;
            cur_q.hold  <= '0;
            cur_q.nrd   <= '0;
            cur_q.rd    <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/ddr_refresh_sched.sv
// Refresh scheduler top: interval timer, owed-refresh counter, refresh
// cycle gate and self-refresh sequencer.
module ddr_refresh_sched #(
    parameter int unsigned T_REFI   = 3120,
    parameter int unsigned T_RFC    = 51,
    parameter int unsigned T_XSNR   = 55,
    parameter int unsigned T_XSRD   = 200,
    parameter int unsigned T_CKE    = 3,
    parameter int unsigned MAX_PEND = 8,
    localparam int unsigned PW      = $clog2(MAX_PEND + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          temp_hi_i,
    input  logic          sref_req_i,
    input  logic          ref_grant_i,
    output logic          ref_req_o,
    output logic          ref_urgent_o,
    output logic [PW-1:0] ref_pending_o,
    output logic          cmd_allow_o,
    output logic          rd_allow_o,
    output logic          cke_o
);
    localparam int unsigned FW = $clog2(T_RFC + 1);

    typedef struct packed {
        logic [FW-1:0] rfc;
    } top_regs_t;

    top_regs_t cur_q, nxt_d;

    logic tick, take, rfc_idle, quiet;
    logic pw_run, pw_self, pw_enter, pw_exit, nrd_ok, rd_ok;

    assign rfc_idle  = (cur_q.rfc == '0);
    assign ref_req_o = pw_run && rfc_idle && (ref_pending_o != '0);
    assign take      = ref_req_o && ref_grant_i;
    assign quiet     = rfc_idle && !take;

    always_comb begin
        nxt_d = cur_q;
        if (take) begin
            nxt_d.rfc = FW'(T_RFC);
        end else if (!rfc_idle) begin
            nxt_d.rfc = cur_q.rfc - FW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.rfc <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    rsch_interval #(.T_REFI(T_REFI)) ival_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (!pw_self),
        .restart_i (pw_exit),
        .temp_hi_i (temp_hi_i),
        .tick_o    (tick)
    );

    rsch_pending #(.MAX_PEND(MAX_PEND), .PW(PW)) pend_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .take_i  (take),
        .clear_i (pw_enter),
        .count_o (ref_pending_o),
        .full_o  (ref_urgent_o)
    );

    rsch_power #(.T_CKE(T_CKE), .T_XSNR(T_XSNR), .T_XSRD(T_XSRD)) pwr_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sref_req_i (sref_req_i),
        .quiet_i    (quiet),
        .cke_o      (cke_o),
        .run_o      (pw_run),
        .self_o     (pw_self),
        .enter_o    (pw_enter),
        .exit_o     (pw_exit),
        .nrd_ok_o   (nrd_ok),
        .rd_ok_o    (rd_ok)
    );

    assign cmd_allow_o = rfc_idle && nrd_ok;
    assign rd_allow_o  = rfc_idle && rd_ok;
endmodule

// File: rtl/rsch_checker.sv
module rsch_checker #(
    parameter int unsigned MAX_PEND = 8,
    parameter int unsigned T_CKE    = 3,
    parameter int unsigned PW       = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          ref_grant_i,
    input logic          ref_req_o,
    input logic [PW-1:0] ref_pending_o,
    input logic          cmd_allow_o,
    input logic          rd_allow_o,
    input logic          cke_o
);
    localparam int unsigned LW = $clog2(T_CKE + 1) + 1;

    logic          cke_prev;
    logic [LW-1:0] run_len;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cke_prev <= 1'b1;
            run_len  <= LW'(T_CKE);
        end else begin
            cke_prev <= cke_o;
            if (cke_o != cke_prev) begin
                run_len <= LW'(1);
            end else if (run_len != LW'(T_CKE)) begin
                run_len <= run_len + LW'(1);
            end
        end
    end

    AST_PEND_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(ref_pending_o) <= int'($past(ref_pending_o)) + 1); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_pending_o <= PW'(MAX_PEND)); // R5
    AST_TAKE_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_req_o && ref_grant_i) |=> ref_pending_o <= $past(ref_pending_o)); // R4
    AST_RFC_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_req_o && ref_grant_i) |=> (!cmd_allow_o && !rd_allow_o && !ref_req_o)); // R6
    AST_SELF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cke_o |-> (!cmd_allow_o && !rd_allow_o && !ref_req_o)); // R7
    AST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cke_o) |-> ref_pending_o == '0); // R7
    AST_CKE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cke_o != cke_prev) |-> run_len >= LW'(T_CKE)); // R8
    AST_READ_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_allow_o |-> cmd_allow_o); // R9
    AST_WAKE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cke_o) |-> (!cmd_allow_o && !rd_allow_o)); // R9
endmodule

bind ddr_refresh_sched rsch_checker #(
    .MAX_PEND (MAX_PEND),
    .T_CKE    (T_CKE),
    .PW       (PW)
) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ref_grant_i   (ref_grant_i),
    .ref_req_o     (ref_req_o),
    .ref_pending_o (ref_pending_o),
    .cmd_allow_o   (cmd_allow_o),
    .rd_allow_o    (rd_allow_o),
    .cke_o         (cke_o)
);

// File: tb/ddr_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module ddr_refresh_sched_tb_top;
    localparam int REFI = 40;
    localparam int RFC  = 5;
    localparam int XSNR = 7;
    localparam int XSRD = 12;
    localparam int CKEM = 3;
    localparam int MAXP = 4;
    localparam int PW   = $clog2(MAXP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic temp_hi = 1'b0, sref = 1'b0, grant = 1'b0;
    logic ref_req, urgent, cmd_ok, rd_ok, cke;
    logic [PW-1:0] pend;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ddr_refresh_sched #(
        .T_REFI(REFI), .T_RFC(RFC), .T_XSNR(XSNR), .T_XSRD(XSRD),
        .T_CKE(CKEM), .MAX_PEND(MAXP)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .temp_hi_i(temp_hi), .sref_req_i(sref),
        .ref_grant_i(grant), .ref_req_o(ref_req), .ref_urgent_o(urgent),
        .ref_pending_o(pend), .cmd_allow_o(cmd_ok), .rd_allow_o(rd_ok),
        .cke_o(cke)
    );

    // Timestamp reference model: st 0 = normal, 1 = self-refresh, 2 = waking
    int now, st, m_pend, next_tick, rfc_free, cke_free, nrd_free, rd_free;
    bit m_cke;

    always @(posedge clk) begin
        if (!rst_n) begin
            now = 0; st = 0; m_pend = 0; next_tick = REFI - 1;
            rfc_free = 0; cke_free = 0; nrd_free = 0; rd_free = 0; m_cke = 1;
        end else begin
            automatic bit rfc_ok = (now >= rfc_free);
            automatic bit req    = (st == 0) && (m_pend > 0) && rfc_ok;
            automatic bit acc    = grant && req;
            automatic bit tick   = (st != 1) && (now == next_tick);
            automatic int ival   = temp_hi ? REFI / 2 : REFI;
            automatic int n      = now + 1;
            if (tick) next_tick = now + ival;
            if (tick && !acc && m_pend < MAXP) m_pend++;
            if (acc && !tick) m_pend--;
            if (acc) rfc_free = n + RFC;
            case (st)
                0: if (sref && rfc_ok && !acc && now >= cke_free) begin
                       st = 1; m_cke = 0; cke_free = n + CKEM - 1; m_pend = 0;
                   end
                1: if (!sref && now >= cke_free) begin
                       st = 2; m_cke = 1; cke_free = n + CKEM - 1;
                       nrd_free = n + XSNR; rd_free = n + XSRD;
                       next_tick = n + ival - 1;
                   end
                default: if (now >= rd_free) st = 0;
            endcase
            now = n;
        end
    end

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0b expected %0b", what, cyc, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit rfc_ok = (now >= rfc_free);
            automatic bit e_req  = (st == 0) && (m_pend > 0) && rfc_ok;
            automatic bit e_cmd  = rfc_ok && (st == 0 || (st == 2 && now >= nrd_free));
            automatic bit e_rd   = rfc_ok && (st == 0 || (st == 2 && now >= rd_free));
            checks++;
            if (int'(pend) != m_pend) begin
                errors++;
                $display("FAIL R1/R2/R4 pending at cycle %0d: actual %0d expected %0d",
                         cyc, pend, m_pend);
            end
            chk(ref_req, e_req, "R3 ref_req");
            chk(urgent, m_pend == MAXP, "R5 urgent");
            chk(cmd_ok, e_cmd, "R6/R7/R9 cmd_allow");
            chk(rd_ok, e_rd, "R9 rd_allow");
            chk(cke, m_cke, "R7/R8 cke");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired: actual %0d cycles expected under 20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        // R1 reset state, before the first edge after release
        checks++;
        if (pend !== '0) begin errors++; $display("FAIL R1 reset pending: actual %0d expected 0", pend); end
        chk(ref_req, 1'b0, "R1 reset ref_req");
        chk(urgent, 1'b0, "R1 reset urgent");
        chk(cke, 1'b1, "R1 reset cke");
        chk(cmd_ok, 1'b1, "R1 reset cmd_allow");
        chk(rd_ok, 1'b1, "R1 reset rd_allow");
        // R5 saturation with no grants
        idle(200);
        // R4 drain, then grants with nothing owed are ignored
        grant = 1'b1; idle(40); grant = 1'b0;
        // R2 derating and mid-interval flag changes
        temp_hi = 1'b1; idle(100);
        temp_hi = 1'b0; idle(13);
        temp_hi = 1'b1; idle(31);
        temp_hi = 1'b0;
        for (int i = 0; i < 20; i++) begin
            grant = 1'b1; idle(1); grant = 1'b0; idle(9);
        end
        // R7 / R9 long self-refresh
        idle(45);
        sref = 1'b1; idle(40); sref = 1'b0; idle(30);
        // R8 very short request
        sref = 1'b1; idle(1); sref = 1'b0; idle(30);
        // R7 entry while a grant is accepted, waking hot for R9
        idle(40);
        grant = 1'b1; sref = 1'b1; idle(1); grant = 1'b0; idle(20);
        temp_hi = 1'b1; sref = 1'b0; idle(60);
        temp_hi = 1'b0;
        for (int i = 0; i < 6; i++) begin
            grant = 1'b1; idle(3); grant = 1'b0; idle(11);
        end
        idle(60);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule